// File: doc/BRIEF.md
# Buck Stage PWM / Hysteretic Mode Selector

This block decides, for a synchronous buck converter, whether the power stage runs at fixed switching frequency (PWM) or in light-load hysteretic mode. In hysteretic mode the low-side switch behaves like a diode. The decision comes from the polarity of the phase node. That polarity is reported once per switching period, at the end of low-side conduction and just before the high-side switch turns on. A positive phase node at that instant means the inductor current has reversed, which is the sign of a light load.

A change of mode needs a run of consecutive same-sign samples: positive samples to leave PWM, negative samples to leave hysteretic mode. This keeps the mode from dithering near the load boundary. A sudden drop of the output below the hysteretic lower level is a second, faster way back to PWM, taken at the next switching tick. A force-PWM strap and a converter enable both pin the block in PWM. The low-side enable output goes low whenever the block is in hysteretic mode, so the output capacitor cannot discharge through the low-side switch.

Top module: `hyst_mode_ctrl`

## Requirements
- R1: Asynchronous reset (rstN low) puts the block in PWM (modeHyst = 0) with the run counter cleared, so that RUN_LEN (default 8) fresh samples are needed before the next change.
- R2: In PWM, RUN_LEN consecutive ticks with phasePos = 1 set modeHyst = 1 on the clock edge of the last such tick.
- R3: A tick whose phasePos points away from a mode change (0 in PWM, 1 in hysteretic mode) clears the run, so a full run of RUN_LEN samples must follow.
- R4: In hysteretic mode, RUN_LEN consecutive ticks with phasePos = 0 return the block to PWM on the edge of the last such tick.
- R5: In hysteretic mode, an assertion of underReg in any cycle returns the block to PWM on the edge of the next tick, or of the same cycle when that cycle carries a tick. No run of samples is needed.
- R6: lowSideEn is 1 only when convEn = 1 and modeHyst = 0. It therefore goes low in the same cycle as the entry into hysteretic mode.
- R7: While forcePwm = 1, modeHyst is 0 from the next edge and the run counter is held clear.
- R8: While convEn = 0, the block is in PWM from the next edge, lowSideEn is 0 and the run is cleared.
- R9: Phase samples in cycles with tick = 0 are ignored.
- R10: An underReg assertion while in PWM is ignored. It does not cut short a later stay in hysteretic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convEn | input | 1 | Converter enable; low holds PWM and low-side off |
| tick | input | 1 | One-cycle strobe per switching period: phasePos is valid |
| phasePos | input | 1 | Phase comparator output at end of low-side conduction; 1 = positive |
| underReg | input | 1 | Output has fallen below the hysteretic lower level |
| forcePwm | input | 1 | Strap that inhibits hysteretic mode |
| modeHyst | output | 1 | 1 = hysteretic mode, 0 = PWM |
| lowSideEn | output | 1 | Permits the low-side switch to conduct between pulses |

## Verification
The assertions assume that tick is a single-cycle strobe and that phasePos is meaningful only in a cycle where tick is high. They also assume that forcePwm, convEn and underReg are synchronous to clk and are sampled like any other input. The stimulus drives every input on the falling edge and raises tick for one cycle per sample. Between ticks it changes phasePos and underReg on purpose, to show that off-tick values have no effect.

// File: rtl/hyst_mode_pkg.sv
package hyst_mode_pkg;

  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } modeE;

  // strobes from the sequencer to the run/pending datapath
  typedef struct packed {
    logic cntStep;   // advance consecutive-sample run
    logic cntClr;    // restart the run from zero
    logic pendClr;   // drop a remembered under-regulation event
  } ctlStrobesT;

endpackage

// File: rtl/mode_run_path.sv
module mode_run_path
  import hyst_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobesT strb,
  input  logic       underReg,
  input  logic       inHyst,
  output logic       runDone,
  output logic       pendUnder
);

  localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] runCnt;

  // consecutive same-sign sample counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             runCnt <= '0;
    else if (strb.cntClr)  runCnt <= '0;
    else if (strb.cntStep) runCnt <= runCnt + CNT_W'(1);
  end

  assign runDone = (runCnt == LAST);

  // under-regulation seen between ticks while hysteretic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pendUnder <= 1'b0;
    else if (strb.pendClr)       pendUnder <= 1'b0;
    else if (underReg && inHyst) pendUnder <= 1'b1;
  end

  // R2: a step advances the run by exactly one
  p_run_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntStep |=> runCnt == $past(runCnt) + CNT_W'(1));

  // R3: a clear strobe restarts the run
  p_run_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> runCnt == '0);

  // R10: pending event only arises in hysteretic mode
  p_pend_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendUnder) |-> $past(inHyst) && $past(underReg));

endmodule

// File: rtl/mode_seq.sv
module mode_seq
  import hyst_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       convEn,
  input  logic       forcePwm,
  input  logic       tick,
  input  logic       phasePos,
  input  logic       underReg,
  input  logic       runDone,
  input  logic       pendUnder,
  output logic       modeHyst,
  output ctlStrobesT strb
);

  modeE modeQ, modeD;
  logic towardChange;

  // sample sign that pushes toward the other mode
  assign towardChange = (modeQ == MODE_PWM) ? phasePos : !phasePos;

  always_comb begin
    modeD = modeQ;
    strb  = '0;
    if (!convEn || forcePwm) begin
      modeD        = MODE_PWM;
      strb.cntClr  = 1'b1;
      strb.pendClr = 1'b1;
    end else if (tick) begin
      if (modeQ == MODE_HYST && (underReg || pendUnder)) begin
        modeD        = MODE_PWM;
        strb.cntClr  = 1'b1;
        strb.pendClr = 1'b1;
      end else if (towardChange) begin
        if (runDone) begin
          modeD        = (modeQ == MODE_PWM) ? MODE_HYST : MODE_PWM;
          strb.cntClr  = 1'b1;
          strb.pendClr = 1'b1;
        end else begin
          strb.cntStep = 1'b1;
        end
      end else begin
        strb.cntClr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_PWM;
    else       modeQ <= modeD;
  end

  assign modeHyst = (modeQ == MODE_HYST);

  // R2: hysteretic entry only on a positive tick that completes a run
  p_hyst_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeHyst) |-> $past(tick) && $past(phasePos) && $past(runDone));

  // R4: every exit from hysteretic mode has a lawful cause
  p_hyst_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeHyst) |-> $past(!convEn || forcePwm ||
      (tick && (underReg || pendUnder || (!phasePos && runDone)))));

  // R5: under-regulation on a tick ends hysteretic mode at once
  p_under_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeHyst && tick && underReg && convEn) |=> !modeHyst);

  // R7: the strap holds PWM
  p_force_pwm_r7: assert property (@(posedge clk) disable iff (!rstN)
    forcePwm |=> !modeHyst);

  // R8: a disabled converter sits in PWM
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !convEn |=> !modeHyst);

  // R9: no mode change without a tick unless forced or disabled
  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && convEn && !forcePwm) |=> $stable(modeHyst));

endmodule

// File: rtl/hyst_mode_ctrl.sv
module hyst_mode_ctrl
  import hyst_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic convEn,
  input  logic tick,
  input  logic phasePos,
  input  logic underReg,
  input  logic forcePwm,
  output logic modeHyst,
  output logic lowSideEn
);

  ctlStrobesT strb;
  logic       runDone;
  logic       pendUnder;

  mode_seq i_seq (
    .clk       (clk),
    .rstN      (rstN),
    .convEn    (convEn),
    .forcePwm  (forcePwm),
    .tick      (tick),
    .phasePos  (phasePos),
    .underReg  (underReg),
    .runDone   (runDone),
    .pendUnder (pendUnder),
    .modeHyst  (modeHyst),
    .strb      (strb)
  );

  mode_run_path #(.RUN_LEN(RUN_LEN)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .underReg  (underReg),
    .inHyst    (modeHyst),
    .runDone   (runDone),
    .pendUnder (pendUnder)
  );

  // diode emulation: no low-side conduction in hysteretic mode or when off
  assign lowSideEn = convEn && !modeHyst;

  // R6: low side never enabled together with hysteretic mode
  p_lowside_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeHyst |-> !lowSideEn);

endmodule

// File: tb/test_hyst_mode_ctrl.sv
module test_hyst_mode_ctrl;

  logic clk = 1'b0;
  logic rstN;
  logic convEn, tick, phasePos, underReg, forcePwm;
  logic modeHyst, lowSideEn;

  int applied = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  hyst_mode_ctrl #(.RUN_LEN(8)) i_hyst_mode_ctrl (
    .clk(clk), .rstN(rstN), .convEn(convEn), .tick(tick),
    .phasePos(phasePos), .underReg(underReg), .forcePwm(forcePwm),
    .modeHyst(modeHyst), .lowSideEn(lowSideEn)
  );

  // {req[14:11], rep[10:7], tick, pos, under, force, en, expHyst, expLow}
  function automatic logic [14:0] vec(input int req, input int rep,
      input logic t, input logic p, input logic u, input logic f,
      input logic e, input logic h, input logic l);
    return {4'(req), 4'(rep), t, p, u, f, e, h, l};
  endfunction

  localparam int NV = 30;
  localparam logic [14:0] VECS [NV] = '{
    vec(2, 7, 1,1,0,0,1, 0,1),   // R2 seven positives: still PWM
    vec(3, 1, 1,0,0,0,1, 0,1),   // R3 negative breaks run
    vec(3, 7, 1,1,0,0,1, 0,1),   // R3 run restarted
    vec(2, 1, 1,1,0,0,1, 1,0),   // R2 eighth positive: hysteretic
    vec(9, 3, 0,0,0,0,1, 1,0),   // R9 off-tick negatives ignored
    vec(4, 7, 1,0,0,0,1, 1,0),   // R4 seven negatives
    vec(4, 1, 1,1,0,0,1, 1,0),   // R4 positive breaks run
    vec(4, 7, 1,0,0,0,1, 1,0),   // R4 seven negatives again
    vec(4, 1, 1,0,0,0,1, 0,1),   // R4 eighth negative: PWM
    vec(6, 7, 1,1,0,0,1, 0,1),   // R6
    vec(6, 1, 1,1,0,0,1, 1,0),   // R6 low side off on entry
    vec(5, 1, 0,1,1,0,1, 1,0),   // R5 off-tick under-regulation
    vec(5, 2, 0,1,0,0,1, 1,0),   // R5 waits for tick
    vec(5, 1, 1,1,0,0,1, 0,1),   // R5 tick: back to PWM
    vec(10,1, 0,0,1,0,1, 0,1),   // R10 under-regulation in PWM
    vec(10,7, 1,1,0,0,1, 0,1),   // R10
    vec(10,1, 1,1,0,0,1, 1,0),   // R10 enter hysteretic
    vec(10,1, 1,0,0,0,1, 1,0),   // R10 no stale pending event
    vec(5, 1, 1,1,1,0,1, 0,1),   // R5 under-regulation on a tick
    vec(7, 7, 1,1,0,0,1, 0,1),   // R7
    vec(7, 1, 1,1,0,0,1, 1,0),   // R7 hysteretic
    vec(7, 1, 0,0,0,1,1, 0,1),   // R7 strap forces PWM
    vec(7, 10,1,1,0,1,1, 0,1),   // R7 strap inhibits entry
    vec(7, 7, 1,1,0,0,1, 0,1),   // R7 run was held clear
    vec(7, 1, 1,1,0,0,1, 1,0),   // R7
    vec(8, 1, 1,1,0,0,0, 0,0),   // R8 disable from hysteretic
    vec(8, 5, 1,1,0,0,1, 0,1),   // R8 partial run
    vec(8, 1, 0,0,0,0,0, 0,0),   // R8 disable clears run
    vec(8, 7, 1,1,0,0,1, 0,1),   // R8 needs fresh run
    vec(8, 1, 1,1,0,0,1, 1,0)    // R8
  };

  task automatic check(input int req, input logic expH, input logic expL);
    applied++;
    if (modeHyst !== expH || lowSideEn !== expL) begin
      bad++;
      $display("FAIL R%0d: modeHyst=%b lowSideEn=%b expected %b %b",
               req, modeHyst, lowSideEn, expH, expL);
    end
  endtask

  task automatic step(input logic t, input logic p, input logic u,
                      input logic f, input logic e);
    @(negedge clk);
    tick = t; phasePos = p; underReg = u; forcePwm = f; convEn = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #150000;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; convEn = 1'b1; tick = 1'b0; phasePos = 1'b0;
    underReg = 1'b0; forcePwm = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(1, 1'b0, 1'b1);  // R1 reset state
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      for (int r = 0; r < int'(VECS[i][10:7]); r++) begin
        step(VECS[i][6], VECS[i][5], VECS[i][4], VECS[i][3], VECS[i][2]);
        check(int'(VECS[i][14:11]), VECS[i][1], VECS[i][0]);
      end
    end

    // R1: reset mid-hysteretic with a partial run pending
    step(1, 1, 0, 0, 1);   // hysteretic now; one positive breaks run
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);   // run of two negatives
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(1, 1'b0, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 7; k++) begin
      step(1, 1, 0, 0, 1);
      check(1, 1'b0, 1'b1);  // R1 counter was cleared
    end
    step(1, 1, 0, 0, 1);
    check(1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule